// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI master read and write a 64-entry, 8-bit register file through a serial port that runs on its own clock. The serial clock, chip select and data inputs are brought into the system clock through two-flop synchronizers. Edges of the serial clock are detected from the synchronized samples, so the system clock must run at least four times faster than the serial clock. Only SPI mode 3 is handled: the serial clock idles high, the slave samples input on the rising edge and changes its output on the falling edge.

Each transaction opens with a command byte, sent most significant bit first. Bit 7 selects the direction (1 = read, 0 = write) and bit 6 requests a burst. Bits 5:0 give the starting register address. Data bytes follow. In a burst the register pointer steps up by one after each data byte and wraps from 0x3F to 0x00. Without a burst only one register is touched, and later bytes in the same transaction are ignored. Raising chip select ends the transaction, discards any partial byte and returns the decoder to the command phase.

Bit 6 of register 0x31 selects the port wiring. When it is 0 (the reset value), a separate input line and output line are used. When it is 1, a single shared line carries data in both directions, and the slave drives it only during the data phase of a read. Register 0x00 holds a fixed identity value (0xA7) and register 0x3A is read-only. Writes to read-only registers are dropped.

Top module: `spi_regport`

## Requirements
- R1: After reset, both output enables are low, register 0x00 reads 0xA7 and every other register (including 0x31) reads 0x00, so the port starts in separate-line mode.
- R2: Output data changes only after a synchronized falling edge of the serial clock, and the master can sample each bit on the next rising edge.
- R3: The command byte is taken MSB first: bit 7 = 1 requests a read and 0 a write, bit 6 = 1 requests a burst, and bits 5:0 are the register address.
- R4: A single write followed by a single read of the same address returns the written byte, and leaves other registers unchanged.
- R5: With the burst bit set, consecutive data bytes go to consecutive registers, for both writes and reads.
- R6: A burst that passes address 0x3F continues at address 0x00.
- R7: With the burst bit clear, data bytes after the first one in the same transaction change no register.
- R8: Raising chip select partway through a byte drops that byte, and the next transaction is again decoded from its command byte.
- R9: Writes to read-only registers (0x00 and 0x3A) leave their contents unchanged.
- R10: Register 0x31 bit 6 = 1 selects shared-line mode. In that mode input bits are taken from the shared line and read data is driven onto it.
- R11: In separate-line mode the output enable is high exactly while chip select is low, and the shared-line enable stays low. In shared-line mode the shared-line enable is high only during the data phase of a read, and falls once chip select rises. The two enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from master, idles high |
| cs_n_i | input | 1 | Active-low chip select |
| ser_i | input | 1 | Serial data input in separate-line mode |
| ser_o | output | 1 | Serial data output in separate-line mode |
| ser_oe_o | output | 1 | Output enable for ser_o |
| sio_i | input | 1 | Shared data line, as sensed at the pad |
| sio_o | output | 1 | Value driven onto the shared line |
| sio_oe_o | output | 1 | Output enable for the shared line |

## Verification
Two functions can fall in the same cycle. At the end of a burst write byte, the same decoder cycle writes register 0x3F and wraps the pointer to the read-only register 0x00. The bench sets this up with a three-byte burst write starting at 0x3E. It then judges the result with a burst read from 0x3E, which must return the two new bytes followed by the unchanged identity value 0xA7. A second collision comes from a write to register 0x31 that switches the wiring mode: the following transactions must then take input and drive output on the shared line, with the enables changing hands as chip select toggles.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs #(
  parameter int                   AW        = 6,
  parameter int                   DW        = 8,
  parameter logic [AW-1:0]        MODE_ADDR = 6'h31,
  parameter int                   MODE_BIT  = 6,
  parameter logic [DW-1:0]        ID_VALUE  = 8'hA7,
  parameter logic [(1<<AW)-1:0]   RO_MASK   = 64'h0400_0000_0000_0001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          mode3w_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == 0) ? ID_VALUE : '0;
    end else if (we && !RO_MASK[waddr]) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata    = mem[raddr];
  assign mode3w_o = mem[MODE_ADDR][MODE_BIT];
endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          fall,
  input  logic          cs_n_s,
  input  logic          din,
  input  logic          mode3w,
  input  logic [DW-1:0] rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic [AW-1:0] raddr,
  output logic          dout_q,
  output logic          ser_oe_q,
  output logic          sio_oe_q
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  phase_t        phase;
  logic          rw, mb;
  logic [AW-1:0] ptr;
  logic [DW-2:0] shin;
  logic [DW-1:0] tx;
  logic [CW-1:0] bcnt;

  logic [DW-1:0] byte_in;
  logic          byte_done;

  assign byte_in   = {shin, din};
  assign byte_done = rise && !cs_n_s && (bcnt == LAST_BIT);

  assign raddr = (phase == PH_CMD) ? byte_in[AW-1:0] : ptr + AW'(1);
  assign we    = byte_done && (phase == PH_DATA) && !rw;
  assign waddr = ptr;
  assign wdata = byte_in;

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      phase <= PH_CMD;
      bcnt  <= '0;
      rw    <= 1'b0;
      mb    <= 1'b0;
      ptr   <= '0;
      shin  <= '0;
      if (rst) begin
        tx     <= '0;
        dout_q <= 1'b1;
      end
    end else begin
      if (rise) begin
        shin <= byte_in[DW-2:0];
        bcnt <= (bcnt == LAST_BIT) ? '0 : bcnt + CW'(1);
      end
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            rw    <= byte_in[DW-1];
            mb    <= byte_in[DW-2];
            ptr   <= byte_in[AW-1:0];
            tx    <= rdata;
            phase <= PH_DATA;
          end
          PH_DATA: begin
            if (mb) begin
              ptr <= ptr + AW'(1);
              tx  <= rdata;
            end else begin
              phase <= PH_DONE;
            end
          end
          default: phase <= PH_DONE;
        endcase
      end
      if (fall && (phase == PH_DATA) && rw) begin
        dout_q <= tx[DW-1];
        tx     <= {tx[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_oe_q <= 1'b0;
      sio_oe_q <= 1'b0;
    end else begin
      ser_oe_q <= !mode3w && !cs_n_s;
      sio_oe_q <= mode3w && !cs_n_s && (phase == PH_DATA) && rw;
    end
  end
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int                 AW        = 6,
  parameter int                 DW        = 8,
  parameter int                 SYNC_STG  = 2,
  parameter logic [AW-1:0]      MODE_ADDR = 6'h31,
  parameter int                 MODE_BIT  = 6,
  parameter logic [DW-1:0]      ID_VALUE  = 8'hA7,
  parameter logic [(1<<AW)-1:0] RO_MASK   = 64'h0400_0000_0000_0001
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic ser_i,
  output logic ser_o,
  output logic ser_oe_o,
  input  logic sio_i,
  output logic sio_o,
  output logic sio_oe_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] pins_s;
  logic             sclk_s, cs_n_s, ser_s, sio_s;
  logic             sclk_prev;
  logic             rise, fall;
  logic             mode3w, din;
  logic             we;
  logic [AW-1:0]    waddr, raddr;
  logic [DW-1:0]    wdata, rdata;
  logic             dout_q, ser_oe_q, sio_oe_q;

  spi_regport_sync #(.N(NSYNC), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({sclk_i, cs_n_i, ser_i, sio_i}),
    .sync_o  (pins_s)
  );

  assign {sclk_s, cs_n_s, ser_s, sio_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b1;
    else     sclk_prev <= sclk_s;
  end

  assign rise = sclk_s && !sclk_prev;
  assign fall = !sclk_s && sclk_prev;
  assign din  = mode3w ? sio_s : ser_s;

  spi_regport_regs #(
    .AW(AW), .DW(DW), .MODE_ADDR(MODE_ADDR), .MODE_BIT(MODE_BIT),
    .ID_VALUE(ID_VALUE), .RO_MASK(RO_MASK)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .raddr    (raddr),
    .rdata    (rdata),
    .mode3w_o (mode3w)
  );

  spi_regport_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .fall     (fall),
    .cs_n_s   (cs_n_s),
    .din      (din),
    .mode3w   (mode3w),
    .rdata    (rdata),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .raddr    (raddr),
    .dout_q   (dout_q),
    .ser_oe_q (ser_oe_q),
    .sio_oe_q (sio_oe_q)
  );

  assign ser_o    = dout_q;
  assign sio_o    = dout_q;
  assign ser_oe_o = ser_oe_q;
  assign sio_oe_o = sio_oe_q;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic clk,
  input logic rst,
  input logic cs_n_s,
  input logic fall,
  input logic mode3w,
  input logic ser_oe,
  input logic sio_oe,
  input logic sio_o
);
  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ser_oe && sio_oe)); // R11

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (!ser_oe && !sio_oe)); // R11

  AST_SIO_OE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    $rose(sio_oe) |-> $past(!cs_n_s)); // R11

  AST_SIO_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    sio_oe |-> $past(mode3w)); // R10

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sio_o) |-> $past(fall)); // R2
endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_n_s (cs_n_s),
  .fall   (fall),
  .mode3w (mode3w),
  .ser_oe (ser_oe_o),
  .sio_oe (sio_oe_o),
  .sio_o  (sio_o)
);

// File: tb/test_spi_regport.sv
module test_spi_regport;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic sclk = 1'b1, cs_n = 1'b1, ser_in = 1'b1, m_drv = 1'b1, m_en = 1'b0;
  logic ser_o, ser_oe, sio_o, sio_oe;
  wire  sio_line = sio_oe ? sio_o : (m_en ? m_drv : 1'b1);

  spi_regport i_spi_regport (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .ser_i(ser_in),
    .ser_o(ser_o), .ser_oe_o(ser_oe), .sio_i(sio_line), .sio_o(sio_o), .sio_oe_o(sio_oe)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit tb_3w = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic last_sio_oe, last_ser_oe, cmd_oe_any;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic r);
    @(negedge clk);
    sclk = 1'b0;
    if (tb_3w) m_drv = b; else ser_in = b;
    repeat (H) @(negedge clk);
    r = tb_3w ? sio_line : ser_o;
    last_sio_oe = sio_oe;
    last_ser_oe = ser_oe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer(input logic rd, input logic mbit, input logic [5:0] a, input int n);
    logic r;
    logic [7:0] cmd;
    cmd = {rd, mbit, a};
    cmd_oe_any = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    m_en = tb_3w;
    repeat (H) @(negedge clk);
    for (int b = 7; b >= 0; b--) begin
      send_bit(cmd[b], r);
      cmd_oe_any = cmd_oe_any | last_sio_oe;
    end
    if (rd) m_en = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      for (int b = 7; b >= 0; b--) begin
        send_bit(wbuf[k][b], r);
        v[b] = r;
      end
      rbuf[k] = v;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    m_en = 1'b0;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic partial(input logic [15:0] word, input int nbits);
    logic r;
    @(negedge clk);
    cs_n = 1'b0;
    m_en = tb_3w;
    repeat (H) @(negedge clk);
    for (int b = 15; b > 15 - nbits; b--) send_bit(word[b], r);
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    m_en = 1'b0;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic wr1(input logic [5:0] a, input logic [7:0] d);
    wbuf[0] = d;
    xfer(1'b0, 1'b0, a, 1);
  endtask

  task automatic rd1(input logic [5:0] a, output logic [7:0] d);
    wbuf[0] = 8'h00;
    xfer(1'b1, 1'b0, a, 1);
    d = rbuf[0];
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 ser_oe after reset", ser_oe, 1'b0);
    chk("R1 sio_oe after reset", sio_oe, 1'b0);
    rd1(6'h00, d); chk("R1 id register", d, 8'hA7);
    chk("R11 ser_oe while selected", last_ser_oe, 1'b1);
    chk("R11 sio_oe stays low in separate mode", last_sio_oe, 1'b0);
    rd1(6'h31, d); chk("R1 mode register reset", d, 8'h00);
    rd1(6'h15, d); chk("R1 plain register reset", d, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] d;
    wr1(6'h10, 8'h5A);
    wr1(6'h11, 8'hC3);
    rd1(6'h10, d); chk("R4 R3 R2 single readback 0x10", d, 8'h5A);
    rd1(6'h11, d); chk("R4 single readback 0x11", d, 8'hC3);
    rd1(6'h12, d); chk("R4 neighbour untouched", d, 8'h00);
  endtask

  task automatic t_burst();
    logic [7:0] d;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    xfer(1'b0, 1'b1, 6'h20, 4);
    rd1(6'h20, d); chk("R5 burst write 0x20", d, 8'h11);
    rd1(6'h23, d); chk("R5 burst write 0x23", d, 8'h44);
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h00;
    xfer(1'b1, 1'b1, 6'h20, 4);
    chk("R5 burst read byte0", rbuf[0], 8'h11);
    chk("R5 burst read byte1", rbuf[1], 8'h22);
    chk("R5 burst read byte2", rbuf[2], 8'h33);
    chk("R5 burst read byte3", rbuf[3], 8'h44);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'h99;
    xfer(1'b0, 1'b1, 6'h3E, 3);
    rd1(6'h3F, d); chk("R6 last register written", d, 8'hE2);
    rd1(6'h00, d); chk("R6 R9 wrap onto read-only id", d, 8'hA7);
    for (int k = 0; k < 3; k++) wbuf[k] = 8'h00;
    xfer(1'b1, 1'b1, 6'h3E, 3);
    chk("R6 wrap read byte0", rbuf[0], 8'hE1);
    chk("R6 wrap read byte1", rbuf[1], 8'hE2);
    chk("R6 wrap read byte2", rbuf[2], 8'hA7);
  endtask

  task automatic t_nomb();
    logic [7:0] d;
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    xfer(1'b0, 1'b0, 6'h08, 2);
    rd1(6'h08, d); chk("R7 first byte written", d, 8'h12);
    rd1(6'h09, d); chk("R7 second byte ignored", d, 8'h00);
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    xfer(1'b1, 1'b0, 6'h21, 2);
    chk("R7 single read first byte", rbuf[0], 8'h22);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    partial({8'h05, 8'hFF}, 12);
    rd1(6'h05, d); chk("R8 partial data byte dropped", d, 8'h00);
    partial({8'h06, 8'h00}, 4);
    wr1(6'h06, 8'h77);
    rd1(6'h06, d); chk("R8 decoder restarts after abort", d, 8'h77);
  endtask

  task automatic t_ro();
    logic [7:0] d;
    wr1(6'h3A, 8'hFF);
    rd1(6'h3A, d); chk("R9 read-only 0x3A unchanged", d, 8'h00);
    wr1(6'h00, 8'h00);
    rd1(6'h00, d); chk("R9 id unchanged", d, 8'hA7);
  endtask

  task automatic t_3wire();
    logic [7:0] d;
    wr1(6'h31, 8'h40);
    tb_3w = 1'b1;
    rd1(6'h10, d); chk("R10 shared-line read", d, 8'h5A);
    chk("R11 sio_oe during read data", last_sio_oe, 1'b1);
    chk("R11 ser_oe low in shared mode", last_ser_oe, 1'b0);
    chk("R11 sio_oe low in command phase", cmd_oe_any, 1'b0);
    chk("R11 sio_oe released after cs", sio_oe, 1'b0);
    wr1(6'h12, 8'h6B);
    chk("R11 sio_oe low during write", last_sio_oe, 1'b0);
    rd1(6'h12, d); chk("R10 shared-line write readback", d, 8'h6B);
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    xfer(1'b1, 1'b1, 6'h22, 2);
    chk("R10 R5 shared burst byte0", rbuf[0], 8'h33);
    chk("R10 R5 shared burst byte1", rbuf[1], 8'h44);
    wr1(6'h31, 8'h00);
    tb_3w = 1'b0;
    rd1(6'h12, d); chk("R10 back to separate lines", d, 8'h6B);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_wrap();
    t_nomb();
    t_abort();
    t_ro();
    t_3wire();
    finish_run();
  end
endmodule